// File: doc/BRIEF.md
# Serial Slot-Select Receiver

This block is the listening end of a three-wire slot-addressing link. It lives in the first slot of a chassis. A controller lowers an active-low frame line, clocks in a 16-bit word most significant bit first on the rising edges of a serial clock, and then raises the frame line again. The block brings all three lines into its system clock through two-flop synchronizers, so the link may run with no fixed phase relation to that clock.

When the frame line falls, every slot in every chassis is released at once. When the frame line rises, the word is decoded. Its low nibble names the slot. The next byte names the chassis. The top nibble is spare. The slot is driven low on a one-hot, active-low select vector only when all of these hold: exactly sixteen serial clock edges arrived, the chassis byte equals the strapped address of this chassis, and the slot number is not zero. Writing an all-zero word is therefore the way to leave nothing selected.

The system clock must be fast enough that three of its cycles fit well inside the release bound (200 ns) and the select bound (350 ns).

Top module: `slot_select_rx`

## Requirements
- R1: While reset is held and after reset is released, every bit of `slot_sel_n` is 1.
- R2: A falling edge on `frame_n` drives every bit of `slot_sel_n` to 1 on the third system clock rising edge after the change. The previous value is held through the second edge.
- R3: While `frame_n` is low, each rising edge of `ser_clk` shifts `ser_data` into the word, most significant bit first. Bits [3:0] hold the slot number and bits [11:4] hold the chassis number.
- R4: A rising edge on `frame_n` that follows exactly 16 serial clock edges, with a matching chassis number and a slot number s from 1 to 15, drives bit s-1 of `slot_sel_n` to 0 and all other bits to 1. This happens on the third system clock edge after the rise.
- R5: If the chassis number differs from `chassis_addr`, all bits of `slot_sel_n` stay 1. The comparison uses the value of `chassis_addr` at the time of the rise.
- R6: A slot number of 0 selects nothing, so a word of zero leaves every bit at 1.
- R7: Word bits [15:12] have no effect on the selection.
- R8: If a frame ends after fewer than or more than 16 serial clock edges, the word is discarded and every bit stays 1.
- R9: Serial clock and data activity while `frame_n` is high does not change `slot_sel_n`.
- R10: At most one bit of `slot_sel_n` is 0 at any time.
- R11: A selection holds unchanged until the next falling edge of `frame_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chassis_addr | input | 8 | Strapped address of this chassis |
| frame_n | input | 1 | Active-low frame strobe, asynchronous |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| slot_sel_n | output | 15 | Active-low one-hot selects; bit s-1 selects slot s |

## Verification
A corrupted bit counter or shift register stays hidden until the frame line rises. It then shows up three cycles later as a wrong slot, a missing select, or a select that should have been withheld. The checks therefore use boundary words whose single-bit shift or truncation would still decode to a valid slot. A stale select register shows up in the other direction: a slot that stays low past the third cycle after the frame line falls. Each frame is therefore sampled both one cycle before and exactly at the expected update edge.

// File: rtl/slot_sel_pkg.sv
package slot_sel_pkg;
    localparam int DEF_WORD_W = 16;
    localparam int DEF_SLOT_W = 4;
    localparam int DEF_CHAS_W = 8;
endpackage

// File: rtl/slot_sel_sync.sv
module slot_sel_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.meta   <= RST_VAL;
            st_q.stable <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/slot_sel_shift.sv
module slot_sel_shift #(
    parameter int WORD_W = slot_sel_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_s,
    input  logic              sck_s,
    input  logic              sda_s,
    output logic [WORD_W-1:0] word_o,
    output logic              start_o,
    output logic              end_o,
    output logic              full_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic              frame_prev;
        logic              sck_prev;
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      fall, rise, sck_rise;

    always_comb begin
        fall     = st_q.frame_prev & ~frame_s;
        rise     = ~st_q.frame_prev & frame_s;
        sck_rise = ~st_q.sck_prev & sck_s;

        st_d            = st_q;
        st_d.frame_prev = frame_s;
        st_d.sck_prev   = sck_s;
        if (fall) begin
            st_d.word = '0;
            st_d.cnt  = '0;
        end else if (!frame_s && sck_rise) begin
            st_d.word = {st_q.word[WORD_W-2:0], sda_s};
            if (st_q.cnt != CNT_OVER) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.frame_prev <= 1'b1;
            st_q.sck_prev   <= 1'b1;
            st_q.word       <= '0;
            st_q.cnt        <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o  = st_q.word;
    assign start_o = fall;
    assign end_o   = rise;
    assign full_o  = (st_q.cnt == CNT_FULL);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_OVER);
    assert_idle_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_s |=> $stable(st_q.word));
    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (st_q.cnt == '0));
    assert_shift_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_s && !start_o && sck_rise) |=> (st_q.word[0] == $past(sda_s)));
endmodule

// File: rtl/slot_sel_decode.sv
module slot_sel_decode #(
    parameter int WORD_W = slot_sel_pkg::DEF_WORD_W,
    parameter int SLOT_W = slot_sel_pkg::DEF_SLOT_W,
    parameter int CHAS_W = slot_sel_pkg::DEF_CHAS_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          end_i,
    input  logic                          full_i,
    input  logic [WORD_W-1:0]             word_i,
    input  logic [CHAS_W-1:0]             chassis_i,
    output logic [(1 << SLOT_W) - 2:0]    sel_n_o
);
    localparam int SLOT_CNT = (1 << SLOT_W) - 1;
    localparam int FIELD_W  = SLOT_W + CHAS_W;

    typedef struct packed {
        logic [SLOT_CNT-1:0] sel;
    } dec_st_t;

    dec_st_t             st_d, st_q;
    logic [SLOT_W-1:0]   slot_num;
    logic [CHAS_W-1:0]   chas_num;
    logic [SLOT_CNT-1:0] onehot;
    logic                hit;

    assign slot_num = word_i[SLOT_W-1:0];
    assign chas_num = word_i[SLOT_W +: CHAS_W];

    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_dec
        assign onehot[g] = (slot_num == SLOT_W'(g + 1));
    end

    if (WORD_W > FIELD_W) begin : g_spare
        logic unused_spare;
        assign unused_spare = ^word_i[WORD_W-1:FIELD_W];
    end

    always_comb begin
        hit  = full_i && (chas_num == chassis_i) && (slot_num != '0);
        st_d = st_q;
        if (start_i) begin
            st_d.sel = '0;
        end else if (end_i) begin
            st_d.sel = hit ? onehot : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_n_o = ~st_q.sel;

    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.sel));
    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.sel == '0));
    assert_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && (chas_num != chassis_i)) |=> (st_q.sel == '0));
    assert_slot_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && (slot_num == '0)) |=> (st_q.sel == '0));
    assert_bad_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && !full_i) |=> (st_q.sel == '0));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !end_i) |=> $stable(st_q.sel));
endmodule

// File: rtl/slot_select_rx.sv
module slot_select_rx #(
    parameter int WORD_W = slot_sel_pkg::DEF_WORD_W,
    parameter int SLOT_W = slot_sel_pkg::DEF_SLOT_W,
    parameter int CHAS_W = slot_sel_pkg::DEF_CHAS_W
) (
    input  logic                       sys_clk,
    input  logic                       rst_n,
    input  logic [CHAS_W-1:0]          chassis_addr,
    input  logic                       frame_n,
    input  logic                       ser_clk,
    input  logic                       ser_data,
    output logic [(1 << SLOT_W) - 2:0] slot_sel_n
);
    logic [2:0]        lines_s;
    logic [WORD_W-1:0] word;
    logic              start, stop, full;

    slot_sel_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .async_i ({frame_n, ser_clk, ser_data}),
        .sync_o  (lines_s)
    );

    slot_sel_shift #(.WORD_W(WORD_W)) u_shift (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .frame_s (lines_s[2]),
        .sck_s   (lines_s[1]),
        .sda_s   (lines_s[0]),
        .word_o  (word),
        .start_o (start),
        .end_o   (stop),
        .full_o  (full)
    );

    slot_sel_decode #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .CHAS_W(CHAS_W)) u_decode (
        .clk       (sys_clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .end_i     (stop),
        .full_i    (full),
        .word_i    (word),
        .chassis_i (chassis_addr),
        .sel_n_o   (slot_sel_n)
    );
endmodule

// File: tb/slot_select_rx_bench.sv
module slot_select_rx_bench;
    localparam int N = 15;
    localparam logic [N-1:0] NONE = '1;

    logic         sys_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   chassis_addr = 8'h12;
    logic         frame_n = 1'b1;
    logic         ser_clk = 1'b1;
    logic         ser_data = 1'b0;
    logic [N-1:0] slot_sel_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [N-1:0] exp;
        string        tag;
    } exp_t;
    exp_t sb_q[$];
    event sample_ev;

    always #2 sys_clk = ~sys_clk;

    slot_select_rx u_slot_select_rx (
        .sys_clk      (sys_clk),
        .rst_n        (rst_n),
        .chassis_addr (chassis_addr),
        .frame_n      (frame_n),
        .ser_clk      (ser_clk),
        .ser_data     (ser_data),
        .slot_sel_n   (slot_sel_n)
    );

    // monitor: pops expected items and compares at the sampling point
    initial begin
        exp_t it;
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (slot_sel_n !== it.exp) begin
                    errors++;
                    $display("FAIL %s: slot_sel_n actual %b expected %b", it.tag, slot_sel_n, it.exp);
                end
            end
        end
    end

    task automatic push(input logic [N-1:0] e, input string tag);
        sb_q.push_back('{e, tag});
        -> sample_ev;
        #1;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge sys_clk);
        @(negedge sys_clk);
    endtask

    function automatic logic [N-1:0] model(input logic [15:0] w, input int nb, input logic [7:0] id);
        logic [N-1:0] m = NONE;
        if (nb == 16 && w[11:4] == id && w[3:0] != 4'd0) m[int'(w[3:0]) - 1] = 1'b0;
        return m;
    endfunction

    task automatic send(input logic [15:0] w, input int nb, inout logic [N-1:0] cur, input string tag);
        frame_n = 1'b0;
        repeat (2) @(posedge sys_clk);
        @(negedge sys_clk);
        push(cur, "R2 hold before release");
        tick(1);
        push(NONE, "R2 release");
        for (int i = 0; i < nb; i++) begin
            ser_data = (i < 16) ? w[15 - i] : 1'b0;
            ser_clk  = 1'b0;
            tick(4);
            ser_clk  = 1'b1;
            tick(4);
        end
        frame_n = 1'b1;
        repeat (2) @(posedge sys_clk);
        @(negedge sys_clk);
        push(NONE, tag);
        tick(1);
        cur = model(w, nb, chassis_addr);
        push(cur, tag);
    endtask

    initial begin
        logic [N-1:0] cur = NONE;
        tick(2);
        push(NONE, "R1 in reset");
        rst_n = 1'b1;
        tick(3);
        push(NONE, "R1 after reset");

        send(16'h0123, 16, cur, "R3 R4 slot 3");
        send(16'hF12F, 16, cur, "R7 R4 slot 15 spare bits set");
        send(16'h0121, 16, cur, "R4 R10 slot 1");

        // R9: serial activity with frame high
        for (int k = 0; k < 6; k++) begin
            ser_data = k[0];
            ser_clk  = 1'b0;
            tick(4);
            ser_clk  = 1'b1;
            tick(4);
        end
        push(cur, "R9 idle serial activity");
        tick(40);
        push(cur, "R11 selection held");

        send(16'h0343, 16, cur, "R5 chassis mismatch");
        send(16'h0125, 16, cur, "R4 slot 5");
        send(16'h0000, 16, cur, "R6 zero word");
        send(16'h0246, 15, cur, "R8 short frame");
        send(16'h0127, 16, cur, "R4 slot 7");
        send(16'h0091, 17, cur, "R8 long frame");

        chassis_addr = 8'h5A;
        send(16'h05A9, 16, cur, "R5 new address match slot 9");
        send(16'h0129, 16, cur, "R5 old address rejected");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule